// File: doc/BRIEF.md
# Timestamp Coincidence Trigger Unit

This block forms a first-level trigger decision from two streams of hit timestamps, one from a master source and one from a slave source. Each stream is written into its own small FIFO. A free-running time counter gives the present time. A stored timestamp is held back until it is older than a programmable latency. This leaves time for hits from both sources to arrive before any decision is made.

When the oldest master entry is old enough, the control logic compares it with the oldest slave entry. A slave hit that falls after the master time, within a programmable gate, is a coincidence. A slave hit at or before the master time can never match, so it is discarded. A master hit that finds nothing in the window is retired without a match. Every time a master entry is retired, a small configurable term combines the coincidence with other digitized inputs using AND, OR and per-input inversion. If the result is true, a one-cycle trigger pulse is sent out together with the master timestamp.

Every time comparison uses modular subtraction, so hit times may run across the counter wrap. The unit takes at most one action per clock cycle.

Top module: `coinc_trigger_unit`

## Requirements
- R1: After reset `rt_now` is 0, and it then rises by one every clock cycle, wrapping modulo 2^TS_W.
- R2: Each source's FIFO holds 2^FIFO_AW entries in arrival order. A write while that FIFO is full is dropped and sets `ovf` in the next cycle. `ovf` stays set until reset.
- R3: A head entry is eligible only when (rt_now - ts) mod 2^TS_W is greater than `offset_cfg`. No trigger appears before its master is eligible.
- R4: With the master head eligible, a slave head with 0 < (s - m) < `gate_cfg` (difference read as signed) is a match once the slave head is also eligible. Both entries are then consumed.
- R5: With the master head eligible, an eligible slave head whose difference (s - m) is zero or negative is discarded, and the master stays.
- R6: With the master head eligible, the master is retired without a match when the slave FIFO is empty or when (s - m) is at least `gate_cfg`. The slave entry stays.
- R7: When a master is retired, the fire decision is: with `or_mode`=0, the match AND every selected aux term; with `or_mode`=1, the match OR any selected aux term. Aux term i is aux_in[i] XOR aux_inv[i], and it is selected when aux_use[i]=1. Unselected inputs have no effect.
- R8: A fire decision gives `trig_out`=1 for one cycle, in the cycle after the decision, with `trig_ts` holding the retired master timestamp. For a match, the decision is made in the cycle where rt_now - s = `offset_cfg`+1, so `trig_out` is seen when rt_now = s + `offset_cfg` + 2. For an unmatched master fired by OR, the same holds with m in place of s.
- R9: Matches and eligibility are decided correctly when master and slave times lie on opposite sides of the counter wrap.
- R10: During and right after reset, `trig_out` and `ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_valid | input | 1 | Write master timestamp this cycle |
| m_ts | input | TS_W | Master hit timestamp |
| s_valid | input | 1 | Write slave timestamp this cycle |
| s_ts | input | TS_W | Slave hit timestamp |
| offset_cfg | input | TS_W | Hold-back latency in counter ticks |
| gate_cfg | input | TS_W | Coincidence window width |
| or_mode | input | 1 | 0 = AND combination, 1 = OR combination |
| aux_in | input | N_AUX | Other digitized trigger inputs |
| aux_use | input | N_AUX | Selects which aux inputs take part |
| aux_inv | input | N_AUX | Inverts each aux input (NOT) |
| trig_out | output | 1 | One-cycle trigger pulse |
| trig_ts | output | TS_W | Master timestamp of the trigger |
| rt_now | output | TS_W | Real-time counter value |
| ovf | output | 1 | Sticky FIFO overflow flag |

## Verification
A trigger is due exactly one register stage after its decision. For a match, that is when rt_now equals the slave time plus the offset plus two. For a master fired only by an OR term, it is the master time plus the offset plus two. The overflow flag is due one cycle after the dropped write. Each time the driver writes hits, it records the expected trigger timestamp together with the rt_now value at which that trigger must appear. The monitor samples on the falling edge and compares both the timestamp and the counter value. The bench reads the counter from the block's own port, so every latency is checked cycle-exactly without any internal probes, and a trigger that arrives early or late fails. Each scenario then waits long enough for all entries to drain and checks that no expected trigger was missed.

// File: rtl/coinc_pkg.sv
`timescale 1ns/1ps
package coinc_pkg;
  // Action taken on the FIFO heads in one cycle.
  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_DROP_S = 2'd1,
    ACT_MATCH  = 2'd2,
    ACT_MISS   = 2'd3
  } act_e;
endpackage

// File: rtl/ts_fifo.sv
`timescale 1ns/1ps
// Show-ahead FIFO: the head word is valid combinationally, so it can be
// compared in the same cycle. The array is written without reset, which
// suits distributed RAM.
module ts_fifo #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;
  logic         do_wr, do_rd;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign head  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/coinc_engine.sv
`timescale 1ns/1ps
// Decides, from the two FIFO heads and the current time, which single
// action to take this cycle. Every difference is taken modulo 2^TS_W.
module coinc_engine
  import coinc_pkg::*;
#(
  parameter int TS_W = 16
) (
  input  logic [TS_W-1:0] rt,
  input  logic [TS_W-1:0] offset_cfg,
  input  logic [TS_W-1:0] gate_cfg,
  input  logic [TS_W-1:0] m_head,
  input  logic            m_empty,
  input  logic [TS_W-1:0] s_head,
  input  logic            s_empty,
  output act_e            act,
  output logic            m_pop,
  output logic            s_pop
);
  logic [TS_W-1:0] m_age, s_age, sep;
  logic            m_ok, s_ok, sep_nonpos;

  always_comb begin
    m_age      = rt - m_head;
    s_age      = rt - s_head;
    sep        = s_head - m_head;
    m_ok       = !m_empty && (m_age > offset_cfg);
    s_ok       = !s_empty && (s_age > offset_cfg);
    sep_nonpos = sep[TS_W-1] || (sep == '0);
    act        = ACT_IDLE;
    if (m_ok) begin
      if (s_empty)              act = ACT_MISS;
      else if (sep_nonpos)      act = s_ok ? ACT_DROP_S : ACT_IDLE;
      else if (sep >= gate_cfg) act = ACT_MISS;
      else if (s_ok)            act = ACT_MATCH;
    end
  end

  assign m_pop = (act == ACT_MATCH) || (act == ACT_MISS);
  assign s_pop = (act == ACT_MATCH) || (act == ACT_DROP_S);
endmodule

// File: rtl/trig_combiner.sv
`timescale 1ns/1ps
// Combines the coincidence result with selected, optionally inverted,
// aux inputs using AND or OR.
module trig_combiner #(
  parameter int N_AUX = 2
) (
  input  logic             matched,
  input  logic             or_mode,
  input  logic [N_AUX-1:0] aux_in,
  input  logic [N_AUX-1:0] aux_use,
  input  logic [N_AUX-1:0] aux_inv,
  output logic             fire
);
  logic [N_AUX-1:0] term_and, term_or;

  for (genvar i = 0; i < N_AUX; i++) begin : g_term
    logic lvl;
    assign lvl         = aux_in[i] ^ aux_inv[i];
    assign term_and[i] = !aux_use[i] || lvl;
    assign term_or[i]  = aux_use[i] && lvl;
  end

  assign fire = or_mode ? (matched || (|term_or)) : (matched && (&term_and));
endmodule

// File: rtl/coinc_trigger_unit.sv
`timescale 1ns/1ps
module coinc_trigger_unit
  import coinc_pkg::*;
#(
  parameter int TS_W    = 16,
  parameter int FIFO_AW = 4,
  parameter int N_AUX   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             m_valid,
  input  logic [TS_W-1:0]  m_ts,
  input  logic             s_valid,
  input  logic [TS_W-1:0]  s_ts,
  input  logic [TS_W-1:0]  offset_cfg,
  input  logic [TS_W-1:0]  gate_cfg,
  input  logic             or_mode,
  input  logic [N_AUX-1:0] aux_in,
  input  logic [N_AUX-1:0] aux_use,
  input  logic [N_AUX-1:0] aux_inv,
  output logic             trig_out,
  output logic [TS_W-1:0]  trig_ts,
  output logic [TS_W-1:0]  rt_now,
  output logic             ovf
);
  logic [TS_W-1:0] m_head, s_head;
  logic            m_empty, m_full, s_empty, s_full;
  logic            m_pop, s_pop, fire, matched;
  act_e            act;

  ts_fifo #(.W(TS_W), .AW(FIFO_AW)) i_mfifo (
    .clk(clk), .rst(rst), .push(m_valid), .din(m_ts), .pop(m_pop),
    .head(m_head), .empty(m_empty), .full(m_full)
  );

  ts_fifo #(.W(TS_W), .AW(FIFO_AW)) i_sfifo (
    .clk(clk), .rst(rst), .push(s_valid), .din(s_ts), .pop(s_pop),
    .head(s_head), .empty(s_empty), .full(s_full)
  );

  coinc_engine #(.TS_W(TS_W)) i_engine (
    .rt(rt_now), .offset_cfg(offset_cfg), .gate_cfg(gate_cfg),
    .m_head(m_head), .m_empty(m_empty), .s_head(s_head), .s_empty(s_empty),
    .act(act), .m_pop(m_pop), .s_pop(s_pop)
  );

  assign matched = (act == ACT_MATCH);

  trig_combiner #(.N_AUX(N_AUX)) i_comb (
    .matched(matched), .or_mode(or_mode), .aux_in(aux_in),
    .aux_use(aux_use), .aux_inv(aux_inv), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rt_now   <= '0;
      trig_out <= 1'b0;
      trig_ts  <= '0;
      ovf      <= 1'b0;
    end else begin
      rt_now   <= rt_now + TS_W'(1);
      trig_out <= m_pop && fire;
      if (m_pop && fire) trig_ts <= m_head;
      if ((m_valid && m_full) || (s_valid && s_full)) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/coinc_trigger_chk.sv
`timescale 1ns/1ps
module coinc_trigger_chk #(
  parameter int TS_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [TS_W-1:0] rt_now,
  input logic [TS_W-1:0] trig_ts,
  input logic [TS_W-1:0] offset_cfg,
  input logic            trig_out,
  input logic            ovf,
  input logic            m_valid,
  input logic            m_full,
  input logic            m_pop,
  input logic            m_empty
);
  logic [TS_W-1:0] trig_age;
  assign trig_age = rt_now - trig_ts;

  // R1
  rt_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rt_now == $past(rt_now) + TS_W'(1)));

  // R2
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  // R2
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_full) |=> ovf);

  // R2
  pop_guard_chk: assert property (@(posedge clk) disable iff (rst)
    m_pop |-> !m_empty);

  // R3
  held_back_chk: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> (trig_age > offset_cfg));
endmodule

bind coinc_trigger_unit coinc_trigger_chk #(.TS_W(TS_W)) i_chk (
  .clk(clk), .rst(rst), .rt_now(rt_now), .trig_ts(trig_ts),
  .offset_cfg(offset_cfg), .trig_out(trig_out), .ovf(ovf),
  .m_valid(m_valid), .m_full(m_full), .m_pop(m_pop), .m_empty(m_empty)
);

// File: tb/test_coinc_trigger_unit.sv
`timescale 1ns/1ps
module test_coinc_trigger_unit;
  localparam int W   = 8;
  localparam int OFF = 60;
  localparam int GT  = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         m_valid = 1'b0, s_valid = 1'b0;
  logic [W-1:0] m_ts = '0, s_ts = '0;
  logic         or_mode = 1'b0;
  logic [1:0]   aux_in = '0, aux_use = '0, aux_inv = '0;
  logic         trig_out, ovf;
  logic [W-1:0] trig_ts, rt_now;
  logic [W-1:0] base;
  int           checks = 0, failures = 0;
  bit           done = 0;

  logic [W-1:0] exp_ts[$];
  logic [W-1:0] exp_rt[$];
  string        exp_tag[$];

  always #10 clk = ~clk;

  coinc_trigger_unit #(.TS_W(W), .FIFO_AW(2), .N_AUX(2)) i_coinc_trigger_unit (
    .clk(clk), .rst(rst), .m_valid(m_valid), .m_ts(m_ts),
    .s_valid(s_valid), .s_ts(s_ts), .offset_cfg(W'(OFF)), .gate_cfg(W'(GT)),
    .or_mode(or_mode), .aux_in(aux_in), .aux_use(aux_use), .aux_inv(aux_inv),
    .trig_out(trig_out), .trig_ts(trig_ts), .rt_now(rt_now), .ovf(ovf)
  );

  function automatic logic [W-1:0] tsk(input int k);
    return W'(int'(base) - 40 + k);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_scn();
    @(negedge clk);
    base = rt_now;
  endtask

  task automatic push_m(input int k);
    @(negedge clk); m_valid = 1'b1; m_ts = tsk(k);
    @(negedge clk); m_valid = 1'b0;
  endtask

  task automatic push_s(input int k);
    @(negedge clk); s_valid = 1'b1; s_ts = tsk(k);
    @(negedge clk); s_valid = 1'b0;
  endtask

  // Driver side of the scoreboard: the trigger timestamp and the counter
  // value at which trig_out must be seen (R8: decision time + 1).
  task automatic expect_trig(input int km, input int kdue, input string tag);
    exp_ts.push_back(tsk(km));
    exp_rt.push_back(W'(int'(tsk(kdue)) + OFF + 2));
    exp_tag.push_back(tag);
  endtask

  task automatic finish_scn(input string tag);
    repeat (130) @(negedge clk);
    check(exp_ts.size() == 0, tag, exp_ts.size(), 0);
    exp_ts.delete(); exp_rt.delete(); exp_tag.delete();
  endtask

  // Monitor side of the scoreboard.
  always @(negedge clk) begin
    if (!rst && trig_out) begin
      if (exp_ts.size() == 0) begin
        check(1'b0, "R8 unexpected trigger ts", int'(trig_ts), -1);
      end else begin
        logic [W-1:0] ets, ert;
        string        tg;
        ets = exp_ts.pop_front();
        ert = exp_rt.pop_front();
        tg  = exp_tag.pop_front();
        check(trig_ts == ets, {tg, " R8 trig_ts"}, int'(trig_ts), int'(ets));
        check(rt_now == ert, {tg, " R8 trigger cycle"}, int'(rt_now), int'(ert));
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r0;
    repeat (3) @(negedge clk);
    check(trig_out == 1'b0, "R10 trig_out in reset", trig_out, 0);
    check(ovf == 1'b0, "R10 ovf in reset", ovf, 0);
    check(rt_now == '0, "R1 rt_now in reset", rt_now, 0);
    rst = 1'b0;
    @(negedge clk);
    r0 = rt_now;
    check(r0 == W'(1), "R1 first count", r0, 1);
    @(negedge clk);
    check(rt_now == r0 + W'(1), "R1 step", rt_now, int'(r0) + 1);
    check(ovf == 1'b0 && trig_out == 1'b0, "R10 after reset", ovf, 0);

    // R4 plain match, diff 2
    start_scn(); push_s(12); push_m(10); expect_trig(10, 12, "R4 match");
    finish_scn("R4 drain");

    // R6 slave too late for first master, matches the second
    start_scn(); push_s(15); push_m(5); push_m(14); expect_trig(14, 15, "R6 late slave");
    finish_scn("R6 drain");

    // R5 stale slave discarded, next slave matches
    start_scn(); push_s(3); push_s(8); push_m(6); expect_trig(6, 8, "R5 stale slave");
    finish_scn("R5 drain");

    // R5/R6 boundaries: diff 0, diff == gate, then empty slave FIFO
    start_scn(); push_s(10); push_s(25); push_m(10); push_m(20); push_m(30);
    finish_scn("R5 R6 boundaries no trigger");

    // R4 boundary: diff == gate - 1 matches
    start_scn(); push_s(24); push_m(20); expect_trig(20, 24, "R4 gate-1");
    finish_scn("R4 gate-1 drain");

    // R6 master alone is retired without a trigger
    start_scn(); push_m(5);
    finish_scn("R6 empty slave");

    // R7 AND mode with selected aux[0] low: match suppressed
    aux_use = 2'b01; aux_in = 2'b00; aux_inv = 2'b00;
    start_scn(); push_s(7); push_m(5);
    finish_scn("R7 AND blocked");

    // R7 AND mode, aux[0] high, unselected aux[1] low has no effect
    aux_in = 2'b01;
    start_scn(); push_s(7); push_m(5); expect_trig(5, 7, "R7 AND pass");
    finish_scn("R7 AND pass drain");

    // R7 NOT: inverted low input passes
    aux_in = 2'b00; aux_inv = 2'b01;
    start_scn(); push_s(7); push_m(5); expect_trig(5, 7, "R7 NOT");
    finish_scn("R7 NOT drain");

    // R7 OR mode: unmatched master fires through aux
    aux_inv = 2'b00; aux_in = 2'b01; or_mode = 1'b1;
    start_scn(); push_m(5); expect_trig(5, 5, "R7 OR aux");
    finish_scn("R7 OR drain");

    // R7 OR mode, aux low: unmatched master gives nothing
    aux_in = 2'b00;
    start_scn(); push_m(5);
    finish_scn("R7 OR quiet");

    // R9 wrap: master at 254, slave at 2
    or_mode = 1'b0; aux_use = 2'b00;
    while (rt_now != W'(20)) @(negedge clk);
    base = rt_now;
    push_s(22); push_m(18); expect_trig(18, 22, "R9 wrap");
    finish_scn("R9 drain");

    // R2 overflow: OR mode fires each retired master; the fifth write is dropped
    or_mode = 1'b1; aux_use = 2'b01; aux_in = 2'b01;
    start_scn();
    for (int k = 0; k < 4; k++) begin
      push_m(k);
      expect_trig(k, k, "R2 kept entry");
    end
    check(ovf == 1'b0, "R2 ovf before full write", ovf, 0);
    push_m(4);
    check(ovf == 1'b1, "R2 ovf after dropped write", ovf, 1);
    finish_scn("R2 drain");
    check(ovf == 1'b1, "R2 ovf sticky", ovf, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule